// File: doc/BRIEF.md
# Queued-Command I2C Master

This block is a single-master I2C/SMBus engine that is driven entirely by a queue of tagged command words. A host pushes words into a command FIFO and the sequencer turns them into bus activity without a handshake per byte. A word may open the bus with a start (or repeated start) and an address byte, send one data byte, or ask for a counted run of received bytes. Any word may also close the bus with a stop. Received bytes land in a receive FIFO that the host pops. Two sticky status flags report that a transaction finished and that a target refused a byte.

A whole SMBus transaction can be queued in one go. It can also be split: a read without stop leaves the bus held with SCL low, so a host can first read a block count and then queue the read for the rest. The SCL rate comes from a divisor in the control word, and two control bits flush either FIFO.

Top module: `i2cq_master`

## Requirements
- R1: A command word carries an 8-bit payload in bits 7:0, a start flag in bit 8, a stop flag in bit 9 and a read flag in bit 10. A word with the start flag produces a start condition, or a repeated start if the bus is held, and then sends the payload MSB first as the address byte.
- R2: A word with neither start nor read sends its payload as one data byte on a held bus. With the stop flag set, a stop condition follows the byte and both lines are released afterwards.
- R3: A word with the read flag receives as many bytes as its payload says and pushes each into the receive FIFO. Every byte is ACKed except the last byte of a read word that carries the stop flag, which is NACKed.
- R4: The receive read port returns the byte in bits 7:0 and sets bit 8 when the receive FIFO is empty.
- R5: A read word without stop leaves the bus held and signals no completion. A later read word continues the same transfer with no new start.
- R6: When the command FIFO runs dry while the bus is held, SCL stays low until the next command arrives.
- R7: If a target NACKs an address or data byte, the master sets status bit 21, issues a stop, and drops queued words up to and including the next word that has the stop flag.
- R8: Status bit 27 is set when a stop condition completes. Bits 27 and 21 each clear only when 1 is written to that bit of the status write port.
- R9: Writing control bit 9 empties the command FIFO and writing control bit 10 empties the receive FIFO. Neither releases a held bus.
- R10: One SCL period lasts 4 times the divisor in control bits 7:0 input-clock cycles. The divisor resets to the parameter default.
- R11: SDA changes only while SCL is low, except for the SDA edges that form start and stop conditions.
- R12: After reset both lines are released, the status word is zero and the receive FIFO is empty.
- R13: When the receive FIFO is full, the next received byte is not started and SCL is held low until the host frees room. No byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_push | input | 1 | Push cmd_word into the command FIFO |
| cmd_word | input | 11 | Command word: payload, start, stop, read |
| rx_pop | input | 1 | Pop one entry from the receive FIFO |
| rx_word | output | 9 | Head of the receive FIFO; bit 8 is the empty flag |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_word | input | 11 | Divisor in 7:0, command flush in 9, receive flush in 10 |
| sts_we | input | 1 | Write-one-to-clear strobe for the status word |
| sts_wdata | input | 32 | Bits written as 1 clear the matching status flags |
| status | output | 32 | Bit 27 transaction ended, bit 21 target NACK |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when high |
| sda_drive_low | output | 1 | Pull SDA low when high |

## Verification
On every cycle the assertions check the following: SDA is steady while SCL is high inside a byte, an idle held bus stays parked, the receive FIFO is never pushed while full, a flush empties a FIFO, a NACK raises its flag, and a completed stop leaves both lines released. Other behaviour can only be shown by the bench's scenarios, run against a modelled target on the open-drain lines: the exact bytes and acknowledge bits on the wire, repeated starts, the drop of queued words after a NACK, a block read paused between two read words, the back-pressure of a full receive FIFO, and the measured SCL period.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
   localparam int CMD_W      = 11;
   localparam int F_START    = 8;
   localparam int F_STOP     = 9;
   localparam int F_READ     = 10;
   localparam int STS_W      = 32;
   localparam int STS_END    = 27;
   localparam int STS_NAK    = 21;
   localparam int CTL_W      = 11;
   localparam int CTL_CMDCLR = 9;
   localparam int CTL_RXCLR  = 10;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_HOLD, SQ_START, SQ_BIT, SQ_STOP, SQ_RXWAIT
   } sq_state_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          empty,
   output logic          full
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("i2cq_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty); // R9
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= (AW+1)'(DEPTH)); // R13
endmodule

// File: rtl/i2cq_qtick.sv
module i2cq_qtick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   assign lim  = (div == '0) ? '0 : div - 1'b1;
   assign tick = en && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en || tick) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (en && div != '0) |-> (cnt < div)); // R10
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
   import i2cq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmd_empty,
   input  logic [CMD_W-1:0] cmd_word,
   output logic             cmd_pop,
   input  logic             rx_full,
   output logic             rx_push,
   output logic [7:0]       rx_byte,
   input  logic             sda_in,
   output logic             run,
   output logic             scl_low,
   output logic             sda_low,
   output logic             xfer_end,
   output logic             nack_hit
);
   sq_state_t   st;
   logic [1:0]  q;
   logic [3:0]  bitn;
   logic [7:0]  sh, rx_left;
   logic        is_rx, stop_pend, held, discard, ack_hi;
   logic        last_q, ack_slot, fetch, last_rx, bit_drive;

   assign last_q   = tick && (q == 2'd3);
   assign ack_slot = (bitn == 4'd8);
   assign fetch    = ((st == SQ_IDLE) || (st == SQ_HOLD)) && !cmd_empty;
   assign cmd_pop  = fetch;
   assign run      = (st == SQ_START) || (st == SQ_BIT) || (st == SQ_STOP);
   assign rx_push  = (st == SQ_BIT) && last_q && ack_slot && is_rx;
   assign rx_byte  = sh;
   assign xfer_end = (st == SQ_STOP) && last_q;
   assign nack_hit = (st == SQ_BIT) && last_q && ack_slot && !is_rx && ack_hi;
   assign last_rx  = stop_pend && (rx_left == 8'd1);

   always_comb begin
      if (!ack_slot) bit_drive = is_rx ? 1'b0 : !sh[7];
      else           bit_drive = is_rx ? !last_rx : 1'b0;
   end

   // line drive per state; a bit slot keeps SCL high only in quarters 1 and 2
   always_comb begin
      scl_low = 1'b0;
      sda_low = 1'b0;
      case (st)
         SQ_HOLD, SQ_RXWAIT: scl_low = 1'b1;
         SQ_START: begin
            scl_low = held && (q == 2'd0);
            sda_low = q[1];
         end
         SQ_BIT: begin
            scl_low = (q == 2'd0) || (q == 2'd3);
            sda_low = bit_drive;
         end
         SQ_STOP: begin
            scl_low = (q == 2'd0);
            sda_low = !q[1];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         q         <= '0;
         bitn      <= '0;
         sh        <= '0;
         rx_left   <= '0;
         is_rx     <= 1'b0;
         stop_pend <= 1'b0;
         held      <= 1'b0;
         discard   <= 1'b0;
         ack_hi    <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE, SQ_HOLD: if (fetch) begin
               q <= '0;
               if (discard) begin
                  if (cmd_word[F_STOP]) discard <= 1'b0;
               end else if (cmd_word[F_START]) begin
                  sh        <= cmd_word[7:0];
                  is_rx     <= 1'b0;
                  stop_pend <= cmd_word[F_STOP];
                  st        <= SQ_START;
               end else if (held) begin
                  stop_pend <= cmd_word[F_STOP];
                  if (cmd_word[F_READ]) begin
                     is_rx   <= 1'b1;
                     rx_left <= cmd_word[7:0];
                     if (cmd_word[7:0] != 8'd0) st <= SQ_RXWAIT;
                     else if (cmd_word[F_STOP]) st <= SQ_STOP;
                  end else begin
                     is_rx <= 1'b0;
                     sh    <= cmd_word[7:0];
                     bitn  <= '0;
                     st    <= SQ_BIT;
                  end
               end
            end
            SQ_START: if (tick) begin
               q <= q + 1'b1;
               if (q == 2'd3) begin
                  st   <= SQ_BIT;
                  bitn <= '0;
                  held <= 1'b1;
               end
            end
            SQ_BIT: if (tick) begin
               q <= q + 1'b1;
               if (q == 2'd2) begin
                  if (is_rx && !ack_slot) sh <= {sh[6:0], sda_in};
                  if (!is_rx && ack_slot) ack_hi <= sda_in;
               end
               if (q == 2'd3) begin
                  if (!ack_slot) begin
                     bitn <= bitn + 1'b1;
                     if (!is_rx) sh <= {sh[6:0], 1'b0};
                  end else if (is_rx) begin
                     rx_left <= rx_left - 1'b1;
                     if (rx_left == 8'd1) st <= stop_pend ? SQ_STOP : SQ_HOLD;
                     else                 st <= SQ_RXWAIT;
                  end else if (ack_hi) begin
                     discard <= !stop_pend;
                     st      <= SQ_STOP;
                  end else begin
                     st <= stop_pend ? SQ_STOP : SQ_HOLD;
                  end
               end
            end
            SQ_RXWAIT: if (!rx_full) begin
               st   <= SQ_BIT;
               bitn <= '0;
               q    <= '0;
            end
            SQ_STOP: if (tick) begin
               q <= q + 1'b1;
               if (q == 2'd3) begin
                  held <= 1'b0;
                  st   <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (st == SQ_BIT && (q == 2'd1 || q == 2'd2)) |-> $stable(sda_low)); // R11
   AST_PARK_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (st == SQ_HOLD && cmd_empty) |=> (st == SQ_HOLD && scl_low)); // R6
   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) xfer_end |=> (!scl_low && !sda_low && !held)); // R2
   AST_HELD_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n) (held && !run) |-> scl_low); // R5
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
   import i2cq_pkg::*;
#(
   parameter int CMD_DEPTH = 8,
   parameter int RX_DEPTH  = 8,
   parameter int DEF_DIV   = 84
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_push,
   input  logic [CMD_W-1:0] cmd_word,
   input  logic             rx_pop,
   output logic [8:0]       rx_word,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_word,
   input  logic             sts_we,
   input  logic [STS_W-1:0] sts_wdata,
   output logic [STS_W-1:0] status,
   input  logic             sda_in,
   output logic             scl_drive_low,
   output logic             sda_drive_low
);
   localparam int DIV_W = 8;

   generate
      if (DEF_DIV < 1 || DEF_DIV > (1 << DIV_W) - 1) begin : g_bad_div
         $error("i2cq_master: DEF_DIV out of range");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             cmd_flush, rx_flush;
   logic             cmd_empty, cmd_full, cmd_pop;
   logic [CMD_W-1:0] cmd_head;
   logic             rx_empty, rx_full, rx_push;
   logic [7:0]       rx_in, rx_head;
   logic             run, tick, xfer_end, nack_hit;
   logic             f_end, f_nak;
   logic             unused_bits;

   assign cmd_flush   = ctl_we && ctl_word[CTL_CMDCLR];
   assign rx_flush    = ctl_we && ctl_word[CTL_RXCLR];
   assign unused_bits = ^{ctl_word[8], sts_wdata, cmd_full};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= DIV_W'(DEF_DIV);
      else if (ctl_we) div_q <= ctl_word[DIV_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_end <= 1'b0;
         f_nak <= 1'b0;
      end else begin
         f_end <= xfer_end || (f_end && !(sts_we && sts_wdata[STS_END]));
         f_nak <= nack_hit || (f_nak && !(sts_we && sts_wdata[STS_NAK]));
      end
   end

   always_comb begin
      status          = '0;
      status[STS_END] = f_end;
      status[STS_NAK] = f_nak;
   end

   assign rx_word = {rx_empty, rx_head};

   i2cq_fifo #(.DW(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
      .clk(clk), .rst_n(rst_n), .flush(cmd_flush),
      .push(cmd_push), .din(cmd_word),
      .pop(cmd_pop), .dout(cmd_head),
      .empty(cmd_empty), .full(cmd_full)
   );

   i2cq_fifo #(.DW(8), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_push), .din(rx_in),
      .pop(rx_pop), .dout(rx_head),
      .empty(rx_empty), .full(rx_full)
   );

   i2cq_qtick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(run), .div(div_q), .tick(tick)
   );

   i2cq_seq u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cmd_empty(cmd_empty), .cmd_word(cmd_head), .cmd_pop(cmd_pop),
      .rx_full(rx_full), .rx_push(rx_push), .rx_byte(rx_in),
      .sda_in(sda_in), .run(run),
      .scl_low(scl_drive_low), .sda_low(sda_drive_low),
      .xfer_end(xfer_end), .nack_hit(nack_hit)
   );

   AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !rx_full); // R13
   AST_NACK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) nack_hit |=> status[STS_NAK]); // R7
   AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) xfer_end |=> status[STS_END]); // R8
endmodule

// File: tb/i2cq_master_bench.sv
module i2cq_master_bench;
   localparam logic [6:0] TADDR = 7'h2A;
   localparam logic [10:0] C_START = 11'h100;
   localparam logic [10:0] C_STOP  = 11'h200;
   localparam logic [10:0] C_READ  = 11'h400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_push = 1'b0;
   logic [10:0] cmd_word = '0;
   logic        rx_pop = 1'b0;
   logic [8:0]  rx_word;
   logic        ctl_we = 1'b0;
   logic [10:0] ctl_word = '0;
   logic        sts_we = 1'b0;
   logic [31:0] sts_wdata = '0;
   logic [31:0] status;
   logic        scl_drive_low, sda_drive_low;
   logic        slv_low = 1'b0;

   wire scl_line = !scl_drive_low;
   wire sda_line = !(sda_drive_low || slv_low);

   int checks = 0;
   int errors = 0;

   always #2 clk = !clk;

   i2cq_master #(.CMD_DEPTH(8), .RX_DEPTH(4), .DEF_DIV(84)) u_i2cq_master (
      .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_word(cmd_word),
      .rx_pop(rx_pop), .rx_word(rx_word), .ctl_we(ctl_we), .ctl_word(ctl_word),
      .sts_we(sts_we), .sts_wdata(sts_wdata), .status(status),
      .sda_in(sda_line), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
   );

   // target model: address TADDR, NACKs a written 0xFF, returns 0xA0 + index on reads
   logic [7:0] wlog [64];
   logic       mack [64];
   int wn = 0, mn = 0, starts_n = 0, stops_n = 0;
   int phase = 0, bitc = 0, rd_idx = 0;
   logic [7:0] tsh = '0, rbyte = '0;
   logic p_scl = 1'b1, p_sda = 1'b1;

   always @(scl_line or sda_line) begin
      if (scl_line != p_scl) begin
         if (scl_line) begin
            if (phase != 0) begin
               if (bitc < 8) tsh = {tsh[6:0], sda_line};
               else if (phase == 3 && mn < 64) begin mack[mn] = sda_line; mn++; end
               bitc++;
            end
         end else if (phase != 0) begin
            if (bitc == 8) begin
               if (phase == 1) slv_low = (tsh[7:1] == TADDR);
               else if (phase == 2) begin
                  if (wn < 64) begin wlog[wn] = tsh; wn++; end
                  slv_low = (tsh != 8'hFF);
               end else slv_low = 1'b0;
            end else if (bitc == 9) begin
               bitc = 0;
               slv_low = 1'b0;
               if (phase == 1) begin
                  if (tsh[7:1] != TADDR) phase = 0;
                  else if (tsh[0]) begin
                     phase = 3; rd_idx = 0; rbyte = 8'hA0; slv_low = !rbyte[7];
                  end else phase = 2;
               end else if (phase == 3) begin
                  if (mack[mn-1] == 1'b0) begin
                     rd_idx++; rbyte = 8'hA0 + 8'(rd_idx); slv_low = !rbyte[7];
                  end else phase = 0;
               end
            end else if (phase == 3 && bitc > 0) slv_low = !rbyte[7-bitc];
         end
      end else if (sda_line != p_sda && scl_line) begin
         if (!sda_line) begin starts_n++; phase = 1; bitc = 0; slv_low = 1'b0; end
         else begin stops_n++; phase = 0; slv_low = 1'b0; end
      end
      p_scl = scl_line;
      p_sda = sda_line;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [10:0] w);
      @(negedge clk); cmd_push = 1'b1; cmd_word = w;
      @(negedge clk); cmd_push = 1'b0;
   endtask

   task automatic ctl(input logic [10:0] w);
      @(negedge clk); ctl_we = 1'b1; ctl_word = w;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic sclr(input logic [31:0] m);
      @(negedge clk); sts_we = 1'b1; sts_wdata = m;
      @(negedge clk); sts_we = 1'b0;
   endtask

   task automatic take(output logic [8:0] v);
      @(negedge clk); v = rx_word; rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   task automatic wait_end();
      @(negedge clk);
      while (status[27] !== 1'b1) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
   end

   initial begin
      logic [8:0] v;
      int w0, m0, s0, p0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 scl", scl_drive_low, 0);
      chk("R12 sda", sda_drive_low, 0);
      chk("R12 status", status, 0);
      chk("R4 empty after reset", rx_word, 9'h100);

      ctl(11'd2);

      // R1 R2 R11 write transaction
      w0 = wn; s0 = starts_n; p0 = stops_n;
      push(C_START | 11'h54); push(11'h010); push(C_STOP | 11'h05A);
      wait_end();
      chk("R2 bytes", wn - w0, 2);
      chk("R1 first byte", wlog[w0], 8'h10);
      chk("R2 stop byte", wlog[w0+1], 8'h5A);
      chk("R11 starts", starts_n - s0, 1);
      chk("R11 stops", stops_n - p0, 1);
      chk("R7 no nack", status[21], 0);
      repeat (4) @(negedge clk);
      chk("R2 released", {scl_drive_low, sda_drive_low}, 0);
      sclr(32'h0800_0000);
      chk("R8 w1c end", status, 0);

      // R3 read word with repeated start
      m0 = mn; s0 = starts_n;
      push(C_START | 11'h54); push(11'h010); push(C_START | 11'h055); push(C_READ | C_STOP | 11'd2);
      wait_end();
      chk("R1 repeated start", starts_n - s0, 2);
      take(v); chk("R3 byte0", v, 9'h0A0);
      take(v); chk("R3 byte1", v, 9'h0A1);
      take(v); chk("R4 empty flag", v[8], 1);
      chk("R3 ack first", mack[m0], 0);
      chk("R3 nack last", mack[m0+1], 1);
      sclr(32'h0820_0000);

      // R5 R6 block read paused after count byte
      push(C_START | 11'h54); push(11'h001); push(C_START | 11'h055); push(C_READ | 11'd1);
      repeat (400) @(negedge clk);
      chk("R6 scl parked low", scl_drive_low, 1);
      chk("R5 no end yet", status[27], 0);
      take(v); chk("R5 count byte", v, 9'h0A0);
      s0 = starts_n;
      push(C_READ | C_STOP | 11'd2);
      wait_end();
      chk("R5 no new start", starts_n - s0, 0);
      take(v); chk("R5 cont byte1", v, 9'h0A1);
      take(v); chk("R5 cont byte2", v, 9'h0A2);
      sclr(32'h0820_0000);

      // R7 address NACK then discard to stop word
      w0 = wn;
      push(C_START | 11'h40); push(11'h011); push(C_STOP | 11'h022);
      push(C_START | 11'h54); push(C_STOP | 11'h033);
      repeat (1500) @(negedge clk);
      chk("R7 nack flag", status[21], 1);
      chk("R7 discard count", wn - w0, 1);
      chk("R7 next txn byte", wlog[w0], 8'h33);
      sclr(32'h0020_0000);
      chk("R8 w1c nak only", status, 32'h0800_0000);
      sclr(32'h0800_0000);

      // R7 data NACK
      w0 = wn;
      push(C_START | 11'h54); push(11'h0FF); push(11'h012); push(C_STOP | 11'h013);
      push(C_START | 11'h54); push(C_STOP | 11'h044);
      repeat (1500) @(negedge clk);
      chk("R7 data nack flag", status[21], 1);
      chk("R7 data discard", wn - w0, 2);
      chk("R7 nacked byte", wlog[w0], 8'hFF);
      chk("R7 after discard", wlog[w0+1], 8'h44);
      sclr(32'h0820_0000);

      // R9 command flush keeps bus held
      w0 = wn;
      push(C_START | 11'h54); push(11'h077); push(C_STOP | 11'h078);
      ctl(11'h202);
      repeat (300) @(negedge clk);
      chk("R9 bus still held", scl_drive_low, 1);
      chk("R9 flushed words", wn - w0, 0);
      push(C_STOP | 11'h079);
      wait_end();
      chk("R9 after flush", wlog[w0], 8'h79);
      sclr(32'h0820_0000);

      // R9 receive flush
      push(C_START | 11'h55); push(C_READ | C_STOP | 11'd2);
      wait_end();
      ctl(11'h402);
      chk("R9 rx flushed", rx_word[8], 1);
      sclr(32'h0820_0000);

      // R10 SCL period with divisor 3
      ctl(11'd3);
      push(C_START | 11'h54); push(C_STOP | 11'h05B);
      begin
         int t, r1, r2;
         logic ps;
         t = 0; r1 = -1; r2 = -1; ps = scl_line;
         while (r2 < 0) begin
            @(negedge clk); t++;
            if (scl_line && !ps) begin
               if (r1 < 0) r1 = t; else r2 = t;
            end
            ps = scl_line;
         end
         chk("R10 period", r2 - r1, 12);
      end
      wait_end();
      sclr(32'h0820_0000);
      ctl(11'd2);

      // R13 receive back-pressure with a 4-entry receive FIFO
      push(C_START | 11'h55); push(C_READ | C_STOP | 11'd6);
      repeat (1500) @(negedge clk);
      chk("R13 stalled no end", status[27], 0);
      chk("R13 scl held", scl_drive_low, 1);
      for (int k = 0; k < 6; k++) begin
         while (rx_word[8]) @(negedge clk);
         take(v);
         chk("R13 byte", v, 9'h0A0 + k);
      end
      wait_end();
      chk("R13 end", status[27], 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule